// File: doc/BRIEF.md
# Rectangle Blit Engine with Colour-Key Transparency

The engine copies one rectangular image into another, one pixel at a time, through a single request/acknowledge memory port. Software first fills a small descriptor store. Each image entry places a rectangle inside a bitmap. Each bitmap entry gives a row pitch and a base address. Software then issues a command that names a target image and a source image, and polls `busy` until the engine returns to idle.

For every destination pixel the engine reads the source pixel. If that pixel equals the key colour, the engine skips it. Otherwise it writes the pixel to the destination. The source descriptor chooses the corner where the walk begins, so a copy between overlapping rectangles in the same bitmap gives the right result. The source descriptor can also mark the source as a pattern. A pattern is tiled across the whole target rectangle, and its offsets wrap at its own width and height.

Top module: `blit_engine`

## Requirements
- R1: After reset `busy` is 0 and `mem_req` is 0. While `busy` is 0, no memory request is made.
- R2: A command word carries the target image index in bits [5:0] and the source image index in bits [11:6]. The target descriptor's width and height set the size of the copy. The pixel at offset (ox,oy) goes from source address `sbase + (sy+oy)*spitch + (sx+ox)` to destination address `dbase + (dy+oy)*dpitch + (dx+ox)`.
- R3: The key colour is sampled when the command is accepted. A source pixel equal to the key is not written, and the destination keeps its old value.
- R4: The corner field of the source descriptor sets where the walk begins: 0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right. Bit 0 makes x decrease and bit 1 makes y decrease. The walk is row-major, and the first write goes to the chosen corner of the target.
- R5: When source and target overlap in one bitmap, a copy that starts from the corner pointing in the direction of the shift leaves the target with the values the source held before the command.
- R6: When the source's pattern flag is set, source offsets are (ox mod sw, oy mod sh). The walk then always starts at the top-left, whatever the corner field says.
- R7: Each pixel uses one read transaction and at most one write transaction. A request holds its address and direction until `mem_ack`.
- R8: `busy` rises in the cycle after the command is accepted. It falls in the cycle after the acknowledge of the last pixel's transaction.
- R9: A command presented while `busy` is 1 is ignored.
- R10: A target with zero width or height makes no memory access, and `busy` is high for exactly one cycle.
- R11: Configuration writes are selected by `cfg_bmp`, `cfg_idx` and `cfg_word`.
  - Image word 0 holds x in [12:0] and y in [28:16].
  - Image word 1 holds width in [12:0] and height in [28:16].
  - Image word 2 holds the bitmap index in [3:0], the corner in [9:8] and the pattern flag in [16].
  - Bitmap word 0 holds the pitch in [12:0].
  - Bitmap word 1 holds the base address.
  - Other words are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_bmp | input | 1 | 1 selects the bitmap store, 0 the image store |
| cfg_idx | input | 6 | Descriptor index |
| cfg_word | input | 2 | Word within the descriptor |
| cfg_wdata | input | 32 | Descriptor write data |
| key_color | input | 16 | Transparent colour |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 12 | Target index [5:0], source index [11:6] |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Pixel address |
| mem_wdata | output | 16 | Write pixel |
| mem_ack | input | 1 | Transaction acknowledge |
| mem_rdata | input | 16 | Read pixel, valid with `mem_ack` |

## Verification
A walker that steps in the wrong direction or wraps at the wrong offset writes a wrong pixel. That error shows in the destination bitmap, and the first write address exposes it on the very first transaction. A latched key or descriptor field that is wrong changes the write count or leaves stale destination values by the end of the command. A sequencer that loses track of the last pixel makes `busy` fall one or more cycles away from the final acknowledge, or leave it high until the watchdog expires.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int CW     = 13;
    localparam int BMP_IW = 4;
    localparam int N_BMP  = 1 << BMP_IW;
    localparam int ADDR_W = 32;

    typedef logic [CW-1:0] coord_t;

    typedef struct packed {
        coord_t              x;
        coord_t              y;
        coord_t              w;
        coord_t              h;
        logic [BMP_IW-1:0]   bmp;
        logic [1:0]          corner;
        logic                pat;
    } img_desc_t;

    typedef struct packed {
        coord_t              pitch;
        logic [ADDR_W-1:0]   base;
    } bmp_desc_t;

    typedef struct packed {
        coord_t ox;
        coord_t oy;
        coord_t px;
        coord_t py;
    } pos_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RD,
        ST_WR
    } st_t;
endpackage

// File: rtl/blit_desc_store.sv
module blit_desc_store
    import blit_pkg::*;
#(
    parameter int N_IMG = 64,
    localparam int IW   = $clog2(N_IMG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sel_bmp,
    input  logic [IW-1:0] idx,
    input  logic [1:0]    word,
    input  logic [31:0]   wdata,
    input  logic [IW-1:0] img_a_idx,
    input  logic [IW-1:0] img_b_idx,
    output img_desc_t     img_a,
    output img_desc_t     img_b,
    input  logic [BMP_IW-1:0] bmp_a_idx,
    input  logic [BMP_IW-1:0] bmp_b_idx,
    output bmp_desc_t     bmp_a,
    output bmp_desc_t     bmp_b
);
    img_desc_t img_d [N_IMG];
    img_desc_t img_q [N_IMG];
    bmp_desc_t bmp_d [N_BMP];
    bmp_desc_t bmp_q [N_BMP];

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        for (int i = 0; i < N_IMG; i++) img_d[i] = img_q[i];
        for (int i = 0; i < N_BMP; i++) bmp_d[i] = bmp_q[i];
        if (we && !sel_bmp && (int'(idx) < N_IMG)) begin
            case (word)
                2'd0: begin
                    img_d[idx].x = wdata[12:0];
                    img_d[idx].y = wdata[28:16];
                end
                2'd1: begin
                    img_d[idx].w = wdata[12:0];
                    img_d[idx].h = wdata[28:16];
                end
                2'd2: begin
                    img_d[idx].bmp    = wdata[BMP_IW-1:0];
                    img_d[idx].corner = wdata[9:8];
                    img_d[idx].pat    = wdata[16];
                end
                default: ;
            endcase
        end
        if (we && sel_bmp && (int'(idx) < N_BMP)) begin
            case (word)
                2'd0: bmp_d[idx[BMP_IW-1:0]].pitch = wdata[12:0];
                2'd1: bmp_d[idx[BMP_IW-1:0]].base  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_IMG; i++) img_q[i] <= '0;
            for (int i = 0; i < N_BMP; i++) bmp_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_IMG; i++) img_q[i] <= img_d[i];
            for (int i = 0; i < N_BMP; i++) bmp_q[i] <= bmp_d[i];
        end
    end

    assign img_a = img_q[img_a_idx];
    assign img_b = img_q[img_b_idx];
    assign bmp_a = bmp_q[bmp_a_idx];
    assign bmp_b = bmp_q[bmp_b_idx];
endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
(
    input  pos_t   cur,
    input  coord_t w,
    input  coord_t h,
    input  coord_t sw,
    input  coord_t sh,
    input  logic   xdir,
    input  logic   ydir,
    input  logic   pat,
    output pos_t   nxt,
    output logic   last
);
    localparam coord_t ONE = coord_t'(1);

    logic row_end;
    logic col_end;

    always_comb begin
        row_end = xdir ? (cur.ox == '0) : (cur.ox == w - ONE);
        col_end = ydir ? (cur.oy == '0) : (cur.oy == h - ONE);
        last    = row_end && col_end;
        nxt     = cur;
        if (!row_end) begin
            nxt.ox = xdir ? cur.ox - ONE : cur.ox + ONE;
            nxt.px = (pat && (cur.px != sw - ONE)) ? cur.px + ONE : '0;
        end else begin
            nxt.ox = xdir ? w - ONE : '0;
            nxt.px = '0;
            nxt.oy = ydir ? cur.oy - ONE : cur.oy + ONE;
            nxt.py = (pat && (cur.py != sh - ONE)) ? cur.py + ONE : '0;
        end
    end
endmodule

// File: rtl/blit_addr.sv
module blit_addr
    import blit_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  coord_t            pitch,
    input  coord_t            org_x,
    input  coord_t            org_y,
    input  coord_t            off_x,
    input  coord_t            off_y,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] row;
    logic [ADDR_W-1:0] col;

    always_comb begin
        row  = ADDR_W'(org_y) + ADDR_W'(off_y);
        col  = ADDR_W'(org_x) + ADDR_W'(off_x);
        addr = base + row * ADDR_W'(pitch) + col;
    end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int N_IMG = 64,
    parameter int PIX_W = 16,
    localparam int IW   = $clog2(N_IMG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_bmp,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [1:0]        cfg_word,
    input  logic [31:0]       cfg_wdata,
    input  logic [PIX_W-1:0]  key_color,
    input  logic              cmd_valid,
    input  logic [2*IW-1:0]   cmd_word,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [PIX_W-1:0]  mem_rdata
);
    localparam coord_t ONE = coord_t'(1);

    typedef struct packed {
        st_t               st;
        logic [IW-1:0]     tgt;
        logic [IW-1:0]     src;
        logic [PIX_W-1:0]  key;
        logic [PIX_W-1:0]  pix;
        pos_t              pos;
        coord_t            w;
        coord_t            h;
        coord_t            sw;
        coord_t            sh;
        coord_t            sx0;
        coord_t            sy0;
        coord_t            dx0;
        coord_t            dy0;
        coord_t            spitch;
        coord_t            dpitch;
        logic [ADDR_W-1:0] sbase;
        logic [ADDR_W-1:0] dbase;
        logic              xdir;
        logic              ydir;
        logic              pat;
    } ctx_t;

    ctx_t q, d;

    img_desc_t img_t, img_s;
    bmp_desc_t bmp_t, bmp_s;
    pos_t      pos_nx;
    logic      pos_last;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    coord_t    soff_x, soff_y;
    logic      start_pat, start_xd, start_yd;

    blit_desc_store #(.N_IMG(N_IMG)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel_bmp   (cfg_bmp),
        .idx       (cfg_idx),
        .word      (cfg_word),
        .wdata     (cfg_wdata),
        .img_a_idx (q.tgt),
        .img_b_idx (q.src),
        .img_a     (img_t),
        .img_b     (img_s),
        .bmp_a_idx (img_t.bmp),
        .bmp_b_idx (img_s.bmp),
        .bmp_a     (bmp_t),
        .bmp_b     (bmp_s)
    );

    blit_walker u_walk (
        .cur  (q.pos),
        .w    (q.w),
        .h    (q.h),
        .sw   (q.sw),
        .sh   (q.sh),
        .xdir (q.xdir),
        .ydir (q.ydir),
        .pat  (q.pat),
        .nxt  (pos_nx),
        .last (pos_last)
    );

    assign soff_x = q.pat ? q.pos.px : q.pos.ox;
    assign soff_y = q.pat ? q.pos.py : q.pos.oy;

    blit_addr u_src_addr (
        .base  (q.sbase),
        .pitch (q.spitch),
        .org_x (q.sx0),
        .org_y (q.sy0),
        .off_x (soff_x),
        .off_y (soff_y),
        .addr  (src_addr)
    );

    blit_addr u_dst_addr (
        .base  (q.dbase),
        .pitch (q.dpitch),
        .org_x (q.dx0),
        .org_y (q.dy0),
        .off_x (q.pos.ox),
        .off_y (q.pos.oy),
        .addr  (dst_addr)
    );

    assign start_pat = img_s.pat;
    assign start_xd  = !start_pat && img_s.corner[0];
    assign start_yd  = !start_pat && img_s.corner[1];

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.tgt = cmd_word[IW-1:0];
                    d.src = cmd_word[2*IW-1:IW];
                    d.key = key_color;
                    d.st  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                d.w      = img_t.w;
                d.h      = img_t.h;
                d.dx0    = img_t.x;
                d.dy0    = img_t.y;
                d.dpitch = bmp_t.pitch;
                d.dbase  = bmp_t.base;
                d.sw     = img_s.w;
                d.sh     = img_s.h;
                d.sx0    = img_s.x;
                d.sy0    = img_s.y;
                d.spitch = bmp_s.pitch;
                d.sbase  = bmp_s.base;
                d.pat    = start_pat;
                d.xdir   = start_xd;
                d.ydir   = start_yd;
                d.pos.ox = start_xd ? img_t.w - ONE : '0;
                d.pos.oy = start_yd ? img_t.h - ONE : '0;
                d.pos.px = '0;
                d.pos.py = '0;
                if ((img_t.w == '0) || (img_t.h == '0) ||
                    (start_pat && ((img_s.w == '0) || (img_s.h == '0))))
                    d.st = ST_IDLE;
                else
                    d.st = ST_RD;
            end
            ST_RD: begin
                if (mem_ack) begin
                    d.pix = mem_rdata;
                    if (mem_rdata == q.key) begin
                        d.pos = pos_nx;
                        d.st  = pos_last ? ST_IDLE : ST_RD;
                    end else begin
                        d.st = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    d.pos = pos_nx;
                    d.st  = pos_last ? ST_IDLE : ST_RD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign mem_req   = (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_we    = (q.st == ST_WR);
    assign mem_addr  = (q.st == ST_WR) ? dst_addr : src_addr;
    assign mem_wdata = q.pix;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R3
    no_key_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata != q.key));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(q.tgt) && $stable(q.src) && $stable(q.key)));

    // R2
    in_rect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((q.pos.ox < q.w) && (q.pos.oy < q.h)));

    // R6
    pat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q.pat) |-> ((q.pos.px < q.sw) && (q.pos.py < q.sh)));
endmodule

// File: tb/blit_engine_bench.sv
module blit_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_bmp = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [1:0]  cfg_word = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] key_color = 16'hFFFF;
    logic        cmd_valid = 1'b0;
    logic [11:0] cmd_word = '0;
    logic        busy, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_ack_cyc = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int first_wr = -1;
    int exp_wr = 0;

    logic [15:0] mem [0:4095];
    logic [15:0] old [0:4095];
    logic [15:0] expm [0:4095];

    int ix[64], iy[64], iw[64], ih[64], ib[64], ic[64], ip[64];
    int bpitch[16], bbase[16];

    always #4 clk = ~clk;

    blit_engine u_blit_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bmp(cfg_bmp),
        .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
        .key_color(key_color), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            last_ack_cyc <= cyc + 1;
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                if (first_wr < 0) first_wr <= int'(mem_addr);
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[11:0]];
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input bit b, input int idx, input int wd, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bmp = b; cfg_idx = 6'(idx); cfg_word = 2'(wd); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_img(input int n, input int x, input int y, input int w, input int h,
                           input int b, input int c, input int p);
        ix[n] = x; iy[n] = y; iw[n] = w; ih[n] = h; ib[n] = b; ic[n] = c; ip[n] = p;
        cfg(1'b0, n, 0, {3'b0, 13'(y), 3'b0, 13'(x)});
        cfg(1'b0, n, 1, {3'b0, 13'(h), 3'b0, 13'(w)});
        cfg(1'b0, n, 2, {15'b0, 1'(p), 6'b0, 2'(c), 4'b0, 4'(b)});
    endtask

    task automatic set_bmp(input int n, input int pitch, input int base);
        bpitch[n] = pitch; bbase[n] = base;
        cfg(1'b1, n, 0, {19'b0, 13'(pitch)});
        cfg(1'b1, n, 1, 32'(base));
    endtask

    task automatic init_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'(i) ^ 16'h5A00;
    endtask

    task automatic model(input int t, input int s);
        exp_wr = 0;
        for (int i = 0; i < 4096; i++) begin old[i] = mem[i]; expm[i] = mem[i]; end
        for (int oy = 0; oy < ih[t]; oy++) begin
            for (int ox = 0; ox < iw[t]; ox++) begin
                int sxo, syo, sa, da;
                sxo = ip[s] != 0 ? ox % iw[s] : ox;
                syo = ip[s] != 0 ? oy % ih[s] : oy;
                sa = bbase[ib[s]] + (iy[s] + syo) * bpitch[ib[s]] + ix[s] + sxo;
                da = bbase[ib[t]] + (iy[t] + oy) * bpitch[ib[t]] + ix[t] + ox;
                if (old[sa % 4096] != key_color) begin
                    expm[da % 4096] = old[sa % 4096];
                    exp_wr++;
                end
            end
        end
    endtask

    task automatic launch(input int t, input int s);
        rd_cnt = 0; wr_cnt = 0; first_wr = -1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = {6'(s), 6'(t)};
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R8 busy rise", int'(busy), 1);
    endtask

    task automatic wait_done();
        int guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(!busy, "R8 finish", int'(busy), 0);
        check(cyc == last_ack_cyc + 1, "R8 busy fall timing", cyc, last_ack_cyc + 1);
    endtask

    task automatic compare(input string req);
        int errs = 0;
        int first = -1;
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== expm[i]) begin errs++; if (first < 0) first = i; end
        check(errs == 0, req, errs, 0);
        if (errs != 0) $display("  first mismatch at %0d", first);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        check(mem_req == 1'b0, "R1 req reset", int'(mem_req), 0);
    endtask

    task automatic t_copy();
        init_mem();
        set_img(0, 2, 3, 8, 5, 0, 0, 0);
        set_img(1, 4, 1, 8, 5, 1, 0, 0);
        model(1, 0);
        launch(1, 0);
        wait_done();
        compare("R2 R11 copy contents");
        check(rd_cnt == 40, "R7 read count", rd_cnt, 40);
        check(wr_cnt == 40, "R7 write count", wr_cnt, 40);
        check(first_wr == 2048 + 32 + 4, "R4 corner 0 first write", first_wr, 2048 + 36);
    endtask

    task automatic t_key();
        init_mem();
        key_color = 16'h1234;
        mem[(3 + 1) * 64 + 2 + 1] = 16'h1234;
        mem[(3 + 4) * 64 + 2 + 7] = 16'h1234;
        mem[(3 + 2) * 64 + 2 + 0] = 16'h1234;
        model(1, 0);
        launch(1, 0);
        key_color = 16'hFFFF;
        wait_done();
        compare("R3 skipped pixels keep old value");
        check(wr_cnt == 37, "R3 write count", wr_cnt, 37);
        check(exp_wr == 37, "R3 model count", exp_wr, 37);
    endtask

    task automatic t_corner();
        init_mem();
        set_img(2, 2, 3, 8, 5, 0, 3, 0);
        model(1, 2);
        launch(1, 2);
        wait_done();
        compare("R4 corner 3 contents");
        check(first_wr == 2048 + 5 * 32 + 11, "R4 corner 3 first write", first_wr, 2048 + 171);
    endtask

    task automatic t_overlap();
        init_mem();
        set_img(3, 10, 10, 8, 4, 0, 1, 0);
        set_img(4, 12, 10, 8, 4, 0, 0, 0);
        model(4, 3);
        launch(4, 3);
        wait_done();
        compare("R5 overlapping shift right");
        check(first_wr == 10 * 64 + 19, "R5 starts top-right", first_wr, 659);
    endtask

    task automatic t_pattern();
        init_mem();
        set_img(5, 40, 40, 3, 2, 0, 3, 1);
        set_img(6, 1, 10, 7, 5, 1, 0, 0);
        model(6, 5);
        launch(6, 5);
        wait_done();
        compare("R6 pattern tiling");
        check(first_wr == 2048 + 10 * 32 + 1, "R6 pattern starts top-left", first_wr, 2369);
        check(rd_cnt == 35, "R6 R7 read count", rd_cnt, 35);
    endtask

    task automatic t_ignore();
        init_mem();
        model(1, 0);
        launch(1, 0);
        repeat (5) @(negedge clk);
        cmd_valid = 1'b1; cmd_word = {6'd5, 6'd6};
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        compare("R9 second command ignored");
        check(wr_cnt == 40, "R9 write count", wr_cnt, 40);
    endtask

    task automatic t_zero();
        int acc;
        set_img(7, 0, 0, 0, 4, 0, 0, 0);
        launch(7, 0);
        @(negedge clk);
        check(busy == 1'b0, "R10 busy one cycle", int'(busy), 0);
        acc = rd_cnt + wr_cnt;
        check(acc == 0, "R10 no access", acc, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        set_bmp(0, 64, 0);
        set_bmp(1, 32, 2048);
        t_copy();
        t_key();
        t_corner();
        t_overlap();
        t_pattern();
        t_ignore();
        t_zero();
        summary();
        $finish;
    end
endmodule